// File: doc/BRIEF.md
# Processor Status Word with Maskable-Interrupt Gate

This block is the 8-bit status register of a small microcontroller core. It holds the arithmetic result flags (carry, auxiliary carry, zero), the two register-bank select bits, the global maskable-interrupt enable and a one-bit in-service priority marker. It also answers one question for the interrupt controller each cycle: may the pending maskable request be acknowledged now?

The core's sequencer drives the block through strobes:
- byte writes and byte restores, which cover return-from-interrupt, return-from-break and pop;
- single-bit set or clear;
- enable-interrupt and disable-interrupt;
- an acknowledge strobe for a vectored interrupt or a software break.

During an acknowledge the block shows the value to be stacked on a separate output. It then clears the enable. When the acknowledged request is maskable, the block also loads the in-service marker from that request's priority flag.

Each cycle a fixed-priority selector picks exactly one update kind: hold, acknowledge, restore, write, bit, disable or enable. A next-value unit applies the chosen update with a `unique case` over that enumeration. The register state therefore moves only along these named transitions:
- hold keeps the value;
- acknowledge clears IE and may load ISP;
- restore loads the whole byte;
- write loads the whole byte;
- bit changes one bit;
- disable clears IE;
- enable sets IE.

Top module: `psw_ctrl`

## Requirements
- R1: While `rst_n` is low the register reads 8'h02, so IE is 0 and ISP is 1.
- R2: Bit positions are fixed: bit 7 IE, bit 6 Z, bit 5 RBS1, bit 4 AC, bit 3 RBS0, bit 2 constant zero, bit 1 ISP, bit 0 CY. A byte write (`wr_en`) loads `wr_data` into the register. The new value appears on `psw_q` after the next rising edge.
- R3: A bit operation (`bit_en`) sets the bit numbered `bit_idx` (0 to 7) to `bit_val` and leaves all other bits unchanged. When `bit_idx` is 2 the operation has no effect.
- R4: `ei` sets IE to 1 and `di` clears IE to 0. When both are high in the same cycle, IE becomes 0.
- R5: While `ack` is high, `stack_data` equals the register value before that cycle's update. While `ack` is low, `stack_data` is 0. After an acknowledge, IE is 0. A non-maskable acknowledge (`ack_maskable` = 0) leaves all other bits unchanged.
- R6: On a maskable acknowledge (`ack` = 1, `ack_maskable` = 1), ISP takes the value of `ack_prio`. A value of 0 marks a high-priority request.
- R7: A restore (`restore_en`) loads the whole register from `restore_data`.
- R8: When several updates are requested in one cycle, only one is applied, in this order: acknowledge, then restore, then byte write, then bit operation, then the enable/disable pair.
- R9: `req_accept` is 1 exactly when `req_valid` is 1, IE is 1, and either ISP is 1 or `req_prio` is 0 (high priority). It is combinational on the current register value.
- R10: Bit 2 always reads 0, whatever a write, restore or bit operation supplies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte write value |
| bit_en | input | 1 | Single-bit operation strobe |
| bit_idx | input | 3 | Bit number for the bit operation |
| bit_val | input | 1 | Value written to the selected bit |
| ei | input | 1 | Enable-interrupt strobe |
| di | input | 1 | Disable-interrupt strobe |
| ack | input | 1 | Vectored acknowledge or software-break strobe |
| ack_maskable | input | 1 | The acknowledged request is maskable |
| ack_prio | input | 1 | Priority flag of the acknowledged request (0 = high) |
| restore_en | input | 1 | Restore strobe (return or pop) |
| restore_data | input | 8 | Byte popped from the stack |
| req_valid | input | 1 | A maskable request is pending |
| req_prio | input | 1 | Priority flag of the pending request (0 = high) |
| psw_q | output | 8 | Current register value, used for read and push |
| stack_data | output | 8 | Value to stack during acknowledge, 0 otherwise |
| req_accept | output | 1 | The pending maskable request may be acknowledged |

## Verification
A vector table walks the register through each single update kind: writes of all-ones and alternating bits, bit set and clear including bit 2, and each enable strobe alone and together. The table then applies combined strobes, each of which tells exactly one priority winner apart from the runner-up. Acknowledge vectors are maskable at each priority and non-maskable, which separates the ISP load from the plain IE clear. Directed tests cover the full IE/ISP/request-priority grid of the accept gate, the pre-update value on `stack_data`, and a reset in the middle of a run.

// File: rtl/psw_pkg.sv
package psw_pkg;

    localparam int PSW_W      = 8;
    localparam int IDX_W      = $clog2(PSW_W);
    localparam int POS_IE     = 7;
    localparam int POS_Z      = 6;
    localparam int POS_RB1    = 5;
    localparam int POS_AC     = 4;
    localparam int POS_RB0    = 3;
    localparam int POS_ZERO   = 2;
    localparam int POS_ISP    = 1;
    localparam int POS_CY     = 0;

    localparam logic [PSW_W-1:0] PSW_RESET = 8'h02;
    localparam logic [PSW_W-1:0] ZERO_MASK = ~(PSW_W'(1) << POS_ZERO);

    typedef enum logic [2:0] {
        UPD_HOLD    = 3'd0,
        UPD_ACK     = 3'd1,
        UPD_RESTORE = 3'd2,
        UPD_WRITE   = 3'd3,
        UPD_BIT     = 3'd4,
        UPD_DI      = 3'd5,
        UPD_EI      = 3'd6
    } upd_t;

endpackage

// File: rtl/psw_upd_sel.sv
module psw_upd_sel
    import psw_pkg::*;
(
    input  logic ack,
    input  logic restore_en,
    input  logic wr_en,
    input  logic bit_en,
    input  logic di,
    input  logic ei,
    output upd_t kind
);

    // Fixed priority: one update kind per cycle.
    always_comb begin
        if (ack)             kind = UPD_ACK;
        else if (restore_en) kind = UPD_RESTORE;
        else if (wr_en)      kind = UPD_WRITE;
        else if (bit_en)     kind = UPD_BIT;
        else if (di)         kind = UPD_DI;
        else if (ei)         kind = UPD_EI;
        else                 kind = UPD_HOLD;
    end

endmodule

// File: rtl/psw_next.sv
module psw_next
    import psw_pkg::*;
(
    input  logic [PSW_W-1:0] cur,
    input  upd_t             kind,
    input  logic [PSW_W-1:0] wr_data,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             bit_val,
    input  logic [PSW_W-1:0] restore_data,
    input  logic             ack_maskable,
    input  logic             ack_prio,
    output logic [PSW_W-1:0] nxt
);

    always_comb begin
        nxt = cur;
        unique case (kind)
            UPD_HOLD:    ;
            UPD_ACK: begin
                nxt[POS_IE] = 1'b0;
                if (ack_maskable) nxt[POS_ISP] = ack_prio;
            end
            UPD_RESTORE: nxt = restore_data;
            UPD_WRITE:   nxt = wr_data;
            UPD_BIT:     nxt[bit_idx] = bit_val;
            UPD_DI:      nxt[POS_IE] = 1'b0;
            UPD_EI:      nxt[POS_IE] = 1'b1;
            default:     nxt = cur;
        endcase
        nxt = nxt & ZERO_MASK;
    end

endmodule

// File: rtl/psw_accept.sv
module psw_accept (
    input  logic req_valid,
    input  logic req_prio,
    input  logic ie,
    input  logic isp,
    output logic accept
);

    // High-priority requests (prio 0) pass even during a high-priority service.
    always_comb accept = req_valid & ie & (isp | ~req_prio);

endmodule

// File: rtl/psw_ctrl.sv
module psw_ctrl
    import psw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PSW_W-1:0] wr_data,
    input  logic             bit_en,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             bit_val,
    input  logic             ei,
    input  logic             di,
    input  logic             ack,
    input  logic             ack_maskable,
    input  logic             ack_prio,
    input  logic             restore_en,
    input  logic [PSW_W-1:0] restore_data,
    input  logic             req_valid,
    input  logic             req_prio,
    output logic [PSW_W-1:0] psw_q,
    output logic [PSW_W-1:0] stack_data,
    output logic             req_accept
);

    upd_t             kind;
    logic [PSW_W-1:0] psw_d;
    logic [PSW_W-1:0] psw_r;

    psw_upd_sel u_sel (
        .ack        (ack),
        .restore_en (restore_en),
        .wr_en      (wr_en),
        .bit_en     (bit_en),
        .di         (di),
        .ei         (ei),
        .kind       (kind)
    );

    psw_next u_next (
        .cur          (psw_r),
        .kind         (kind),
        .wr_data      (wr_data),
        .bit_idx      (bit_idx),
        .bit_val      (bit_val),
        .restore_data (restore_data),
        .ack_maskable (ack_maskable),
        .ack_prio     (ack_prio),
        .nxt          (psw_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psw_r <= PSW_RESET;
        else        psw_r <= psw_d;
    end

    always_comb begin
        psw_q      = psw_r;
        stack_data = ack ? psw_r : '0;
    end

    psw_accept u_acc (
        .req_valid (req_valid),
        .req_prio  (req_prio),
        .ie        (psw_r[POS_IE]),
        .isp       (psw_r[POS_ISP]),
        .accept    (req_accept)
    );

    // R9: acceptance needs a request and IE set
    a_r9_accept_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
        req_accept |-> (req_valid && psw_q[POS_IE]));

    // R9: a low-priority request is never accepted during a high-priority service
    a_r9_low_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_prio && !psw_q[POS_ISP]) |-> !req_accept);

    // R5: IE is clear after every acknowledge
    a_r5_ack_clears_ie: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !psw_q[POS_IE]);

    // R6: a maskable acknowledge loads ISP from the request priority
    a_r6_isp_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ack_maskable) |=> (psw_q[POS_ISP] == $past(ack_prio)));

    // R7: a restore without an acknowledge loads the stacked byte
    a_r7_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_en && !ack) |=> (psw_q == ($past(restore_data) & ZERO_MASK)));

    // R4: di wins over ei when nothing of higher rank is active
    a_r4_di_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (di && !ack && !restore_en && !wr_en && !bit_en) |=> !psw_q[POS_IE]);

    // R10: bit 2 never reads 1
    a_r10_zero_bit: assert property (@(posedge clk) disable iff (!rst_n)
        !psw_q[POS_ZERO]);

endmodule

// File: tb/sim_psw_ctrl.sv
module sim_psw_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 0, bit_en = 0, bit_val = 0, ei = 0, di = 0;
    logic       ack = 0, ack_maskable = 0, ack_prio = 0, restore_en = 0;
    logic       req_valid = 0, req_prio = 0;
    logic [7:0] wr_data = 0, restore_data = 0;
    logic [2:0] bit_idx = 0;
    logic [7:0] psw_q, stack_data;
    logic       req_accept;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    psw_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .bit_en(bit_en), .bit_idx(bit_idx), .bit_val(bit_val),
        .ei(ei), .di(di), .ack(ack), .ack_maskable(ack_maskable),
        .ack_prio(ack_prio), .restore_en(restore_en),
        .restore_data(restore_data), .req_valid(req_valid),
        .req_prio(req_prio), .psw_q(psw_q), .stack_data(stack_data),
        .req_accept(req_accept)
    );

    typedef struct packed {
        logic       wr;
        logic [7:0] wd;
        logic       be;
        logic [2:0] bi;
        logic       bv;
        logic       e;
        logic       d;
        logic       a;
        logic       am;
        logic       ap;
        logic       rs;
        logic [7:0] rd;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 20;
    // fields: wr wd be bi bv ei di ack am ap rs rd exp req
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'hFF, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFB, 4'd10}, // R10 write all ones
        '{1'b1, 8'h55, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h51, 4'd2},  // R2
        '{1'b0, 8'h00, 1'b1, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hD1, 4'd3},  // R3 set bit 7
        '{1'b0, 8'h00, 1'b1, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hD1, 4'd3},  // R3 bit 2 ignored
        '{1'b0, 8'h00, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hD0, 4'd3},  // R3 clear CY
        '{1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h50, 4'd4},  // R4 di
        '{1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hD0, 4'd4},  // R4 ei
        '{1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h50, 4'd4},  // R4 both
        '{1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hD0, 4'd4},  // R4 ei
        '{1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h50, 4'd5},  // R5 non-maskable ack
        '{1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hDF, 8'hDB, 4'd7},  // R7 restore
        '{1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h59, 4'd6},  // R6 high prio ack
        '{1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h86, 8'h82, 4'd7},  // R7 restore
        '{1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h02, 4'd6},  // R6 low prio ack
        '{1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 8'hFB, 4'd10}, // R10 restore ones
        '{1'b1, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h7B, 4'd8},  // R8 ack wins
        '{1'b1, 8'h00, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h81, 8'h81, 4'd8},  // R8 restore wins
        '{1'b1, 8'h40, 1'b1, 3'd6, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h40, 4'd8},  // R8 write wins
        '{1'b0, 8'h00, 1'b1, 3'd7, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hC0, 4'd8},  // R8 bit wins
        '{1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hC0, 4'd4}   // R4 ei when set
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        wr_en = 0; bit_en = 0; bit_val = 0; ei = 0; di = 0; ack = 0;
        ack_maskable = 0; ack_prio = 0; restore_en = 0; wr_data = 0;
        restore_data = 0; bit_idx = 0;
    endtask

    task automatic do_restore(input logic [7:0] v);
        @(negedge clk);
        restore_en = 1; restore_data = v;
        @(negedge clk);
        clear_in();
    endtask

    task automatic acc_check(input string req, input logic v, input logic p, input logic exp);
        @(negedge clk);
        req_valid = v; req_prio = p;
        #1;
        check8(req, {7'd0, req_accept}, {7'd0, exp});
        req_valid = 0; req_prio = 0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 20000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1 reset state
        #25;
        check8("R1 reset value", psw_q, 8'h02);
        check8("R5 stack_data idle", stack_data, 8'h00);
        rst_n = 1'b1;
        acc_check("R9 IE clear after reset", 1'b1, 1'b0, 1'b0);

        // vector walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = VEC[i].wr; wr_data = VEC[i].wd; bit_en = VEC[i].be;
            bit_idx = VEC[i].bi; bit_val = VEC[i].bv; ei = VEC[i].e; di = VEC[i].d;
            ack = VEC[i].a; ack_maskable = VEC[i].am; ack_prio = VEC[i].ap;
            restore_en = VEC[i].rs; restore_data = VEC[i].rd;
            @(negedge clk);
            clear_in();
            check8($sformatf("R%0d vector %0d", VEC[i].req, i), psw_q, VEC[i].exp);
        end

        // R5: stacked value is the value before the acknowledge
        do_restore(8'hD9);
        @(negedge clk);
        ack = 1; ack_maskable = 1; ack_prio = 0;
        #1;
        check8("R5 stack_data during ack", stack_data, 8'hD9);
        @(negedge clk);
        clear_in();
        #1;
        check8("R5 stack_data after ack", stack_data, 8'h00);
        check8("R6 value after ack", psw_q, 8'h59);

        // R9 accept gate grid
        do_restore(8'h82);
        acc_check("R9 IE1 ISP1 low", 1'b1, 1'b1, 1'b1);
        acc_check("R9 IE1 ISP1 high", 1'b1, 1'b0, 1'b1);
        acc_check("R9 no request", 1'b0, 1'b0, 1'b0);
        do_restore(8'h80);
        acc_check("R9 IE1 ISP0 low", 1'b1, 1'b1, 1'b0);
        acc_check("R9 IE1 ISP0 high", 1'b1, 1'b0, 1'b1);
        do_restore(8'h02);
        acc_check("R9 IE0 ISP1", 1'b1, 1'b1, 1'b0);

        // R1 reset mid-run
        do_restore(8'hF9);
        @(negedge clk);
        rst_n = 0;
        #2;
        check8("R1 reset mid-run", psw_q, 8'h02);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check8("R1 hold after reset", psw_q, 8'h02);

        finish_run();
    end

endmodule